// File: doc/BRIEF.md
# NOR Flash Pin-Level Behavioural Emulator

This block stands in for a small NOR flash device and is seen only from its pin side. A memory controller under test drives the active-low chip enable, output enable and write enable pins, an address bus and a write data bus. The block returns read data and a busy flag. All pins are sampled on a free-running system clock, so an asynchronous bus driven from that clock can be emulated with ordinary flops.

Writes are never applied to the array directly. Each rising edge of write enable taken while chip enable is low is one command cycle. A command decoder looks for an unlock prefix and then either a program command or a chip-erase command. A program can only clear bits, so the stored word becomes the old word ANDed with the new data. Only the chip-erase sequence sets words back to all ones. After either operation the device stays busy for a programmable number of clocks. During that time reads show a fixed marker value and write cycles are dropped.

Top module: `nor_emu`

## Requirements
- R1: After reset, busy is low and every word reads as all ones.
- R2: dout_oe is high exactly when ce_n and oe_n are both low. When the device is not busy, dout shows the word selected by the low log2(DEPTH) address bits.
- R3: The program sequence is four write cycles: (addr h555, data hAA), (h2AA, h55), (h555, hA0), then (target address, data). The target word becomes its old value ANDed with the data.
- R4: Programming can never turn a 0 bit into a 1. Programming h05 over a stored h0A leaves h00.
- R5: The six-cycle sequence (h555,hAA), (h2AA,h55), (h555,h80), (h555,hAA), (h2AA,h55), (h555,h10) sets every word to all ones.
- R6: A write cycle that does not match the next expected step returns the decoder to idle. A later data cycle without a full fresh prefix changes nothing, and a broken erase sequence erases nothing.
- R7: A write-enable rising edge taken while ce_n is high is not a command cycle.
- R8: Busy goes high on the first clock after the final write cycle of a program or erase is sampled. It stays high for PROG_CYC clocks after a program and for ERASE_CYC clocks after an erase.
- R9: While busy, dout shows BUSY_VAL and every write cycle is ignored.
- R10: Command addresses are compared over all ADDR_W bits. A cycle at h455 in place of h555 breaks the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its rising edge marks a write cycle |
| addr | input | ADDR_W | Word address / command address |
| din | input | DATA_W | Write data / command code |
| dout | output | DATA_W | Read data, or BUSY_VAL while busy |
| dout_oe | output | 1 | Read drive enable |
| busy | output | 1 | An operation is completing |

## Verification
The assertions assume that addr and din are held steady while we_n goes through its rising edge. They also assume that a low-to-high change of we_n lasts at least one clock on each side, so that every write cycle is seen exactly once. The bench drives each write cycle over three clock periods, on falling edges only. It raises we_n one clock after lowering it and only then releases chip enable, so every pulse stays inside these limits. Reads change the address only between cycles, which keeps the assertion that a stored word never gains a one bit meaningful.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERA3,
    ST_ERA4,
    ST_ERA5
  } cmd_st_t;
endpackage

// File: rtl/nor_emu_cmd.sv
module nor_emu_cmd
  import nor_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              prog_go,
  output logic              erase_go
);
  localparam logic [ADDR_W-1:0] A_MAIN = 'h555;
  localparam logic [ADDR_W-1:0] A_ALT  = 'h2AA;
  localparam logic [DATA_W-1:0] D_K1   = 'hAA;
  localparam logic [DATA_W-1:0] D_K2   = 'h55;
  localparam logic [DATA_W-1:0] D_PGM  = 'hA0;
  localparam logic [DATA_W-1:0] D_ERS  = 'h80;
  localparam logic [DATA_W-1:0] D_CHIP = 'h10;

  cmd_st_t st_q, st_d;
  logic    step;
  logic    key1, key2;

  assign step = wr_stb && !busy;
  assign key1 = (addr == A_MAIN) && (din == D_K1);
  assign key2 = (addr == A_ALT)  && (din == D_K2);

  always_comb begin
    st_d     = st_q;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    if (step) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (key1) st_d = ST_UNL1;
        ST_UNL1: if (key2) st_d = ST_UNL2;
        ST_UNL2: begin
          if (addr == A_MAIN && din == D_PGM) st_d = ST_PROG;
          else if (addr == A_MAIN && din == D_ERS) st_d = ST_ERA3;
        end
        ST_PROG: prog_go = 1'b1;
        ST_ERA3: if (key1) st_d = ST_ERA4;
        ST_ERA4: if (key2) st_d = ST_ERA5;
        ST_ERA5: erase_go = (addr == A_MAIN) && (din == D_CHIP);
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else if (step) st_q <= st_d;
  end

  // R9: no operation may start while the timer reports busy
  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_go || erase_go));

  // R3 / R5: a single cycle launches at most one operation
  p_single_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_go && erase_go));
endmodule

// File: rtl/nor_emu_busy.sv
module nor_emu_busy #(
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_go,
  input  logic erase_go,
  output logic busy
);
  localparam int CNT_W = $clog2(ERASE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = prog_go || erase_go || (cnt_q != '0);

  always_comb begin
    if (erase_go)      cnt_d = CNT_W'(ERASE_CYC);
    else if (prog_go)  cnt_d = CNT_W'(PROG_CYC);
    else               cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nor_emu_array.sv
module nor_emu_array #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_go,
  input  logic                     erase_go,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;
    logic              hit, word_en;

    assign hit     = prog_go && (wr_idx == IDX_W'(g));
    assign word_en = erase_go || hit;
    assign word_d  = erase_go ? '1 : (word_q & wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '1;
      else if (word_en) word_q <= word_d;
    end

    assign mem[g] = word_q;
  end

  assign rd_data = mem[rd_idx];

  // R3: bits that are zero in the program data are zero afterwards
  p_prog_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> (mem[$past(wr_idx)] & ~$past(wr_data)) == '0);

  // R4: without an erase, a watched word never gains a one bit
  p_no_set_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_idx) && !$past(erase_go)) |-> (rd_data & ~$past(rd_data)) == '0);

  // R5: after chip erase the selected word is all ones
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> rd_data == '1);
endmodule

// File: rtl/nor_emu.sv
module nor_emu #(
  parameter int              ADDR_W    = 11,
  parameter int              DATA_W    = 8,
  parameter int              DEPTH     = 256,
  parameter int              PROG_CYC  = 20,
  parameter int              ERASE_CYC = 100,
  parameter logic [DATA_W-1:0] BUSY_VAL = 'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              busy
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              we_q;
  logic              wr_stb;
  logic              prog_go, erase_go;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) we_q <= 1'b1;
    else             we_q <= we_n;
  end

  assign wr_stb = !we_q && we_n && !ce_n;

  nor_emu_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_stb   (wr_stb),
    .busy     (busy),
    .addr     (addr),
    .din      (din),
    .prog_go  (prog_go),
    .erase_go (erase_go)
  );

  nor_emu_busy #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_busy (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .busy     (busy)
  );

  nor_emu_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .wr_idx   (addr[IDX_W-1:0]),
    .wr_data  (din),
    .rd_idx   (addr[IDX_W-1:0]),
    .rd_data  (rd_data)
  );

  assign dout    = busy ? BUSY_VAL : rd_data;
  assign dout_oe = !ce_n && !oe_n;

  // R8: a launched operation is always followed by busy
  p_busy_after_go_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (prog_go || erase_go) |=> busy);

  // R7: with chip enable high no operation can start
  p_ce_gates_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    ce_n |-> !(prog_go || erase_go));
endmodule

// File: tb/nor_emu_bench.sv
module nor_emu_bench;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int PCYC   = 4;
  localparam int ECYC   = 9;
  localparam logic [7:0] BVAL = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_oe, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [DEPTH];

  always #2 clk = ~clk;

  nor_emu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PROG_CYC(PCYC),
            .ERASE_CYC(ECYC), .BUSY_VAL(BVAL)) u_nor_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input logic [10:0] a, input logic [7:0] d, input bit ce_hi = 0);
    @(negedge clk); ce_n = ce_hi; addr = a; din = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic prog(input logic [10:0] a, input logic [7:0] d, input bit ce_hi = 0);
    wcyc(11'h555, 8'hAA, ce_hi); wcyc(11'h2AA, 8'h55, ce_hi);
    wcyc(11'h555, 8'hA0, ce_hi); wcyc(a, d, ce_hi);
  endtask

  task automatic erase();
    wcyc(11'h555, 8'hAA); wcyc(11'h2AA, 8'h55); wcyc(11'h555, 8'h80);
    wcyc(11'h555, 8'hAA); wcyc(11'h2AA, 8'h55); wcyc(11'h555, 8'h10);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 d = dout;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(11'(i), v);
      check(v === exp_mem[i], req, v, exp_mem[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(busy === 1'b0, "R1 busy", busy, 0);
    check_all("R1/R2 erased read");

    // R2: output enable truth table
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); ce_n = c[0]; oe_n = c[1];
      #1 check(dout_oe === (c == 0), "R2 dout_oe", dout_oe, c == 0);
    end
    ce_n = 1'b1; oe_n = 1'b1;

    // R3/R8: program every word, busy length each time
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] p;
      p = 8'((i * 37 + 5) & 8'hFF);
      prog(11'(i), p);
      busy_len(n);
      check(n == PCYC, "R8 program busy", n, PCYC);
      exp_mem[i] = exp_mem[i] & p;
    end
    check_all("R3 program sweep");

    // R3: second pass shows AND with old content
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] p;
      p = 8'((i * 91 + 200) & 8'hFF);
      prog(11'(i), p);
      busy_len(n);
      exp_mem[i] = exp_mem[i] & p;
    end
    check_all("R3 AND over old data");

    // R5/R8: chip erase
    erase();
    busy_len(n);
    check(n == ECYC, "R8 erase busy", n, ECYC);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    check_all("R5 chip erase");

    // R4: 05 over 0A gives 00
    prog(11'd2, 8'h0A); busy_len(n);
    prog(11'd2, 8'h05); busy_len(n);
    rd(11'd2, v);
    check(v === 8'h00, "R4 no bit set", v, 0);
    exp_mem[2] = 8'h00;

    // R9: busy read marker and ignored writes
    erase();
    rd(11'd2, v);
    check(v === BVAL, "R9 busy marker", v, BVAL);
    wcyc(11'h555, 8'hAA); wcyc(11'h2AA, 8'h55);
    wcyc(11'h555, 8'hA0); wcyc(11'd7, 8'h00);
    busy_len(n);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    rd(11'd7, v);
    check(v === 8'hFF, "R9 writes ignored while busy", v, 8'hFF);

    // R6: wrong third code aborts, lone data cycle does nothing
    wcyc(11'h555, 8'hAA); wcyc(11'h2AA, 8'h55); wcyc(11'h555, 8'h77);
    wcyc(11'd5, 8'h00);
    busy_len(n);
    check(n == 0, "R6 abort no busy", n, 0);
    rd(11'd5, v);
    check(v === 8'hFF, "R6 abort program", v, 8'hFF);

    // R6: broken erase sequence erases nothing
    prog(11'd9, 8'h3C); busy_len(n); exp_mem[9] = 8'h3C;
    wcyc(11'h555, 8'hAA); wcyc(11'h2AA, 8'h55); wcyc(11'h555, 8'h80);
    wcyc(11'h555, 8'hAA); wcyc(11'h2AA, 8'h54); wcyc(11'h555, 8'h10);
    busy_len(n);
    rd(11'd9, v);
    check(v === 8'h3C, "R6 broken erase", v, 8'h3C);

    // R7: chip enable high
    prog(11'd4, 8'h00, 1'b1);
    busy_len(n);
    check(n == 0, "R7 no busy ce high", n, 0);
    rd(11'd4, v);
    check(v === 8'hFF, "R7 ce high ignored", v, 8'hFF);

    // R10: full-width command address
    wcyc(11'h455, 8'hAA); wcyc(11'h2AA, 8'h55); wcyc(11'h555, 8'hA0);
    wcyc(11'd6, 8'h00);
    busy_len(n);
    rd(11'd6, v);
    check(v === 8'hFF, "R10 alias address", v, 8'hFF);

    check_all("R2 final contents");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule